// File: doc/BRIEF.md
# Configuration Space Access Decoder

This block serves configuration reads and writes for a fixed group of functions on one bus. A request names a bus, a device, a function, a register offset, byte enables and write data. The block first decides whether the addressed function exists. It then decides whether the addressed register exists inside that function. It then returns exactly one completion, which carries read data and a one-bit status.

Every implemented function reports its identification word and a class word. Each one also holds a private 32-bit scratch register that software can read and write. A missing function and a missing register are treated differently. A read to a missing function completes as a master abort and returns all ones. A missing register inside a present function reads as zero. Every write completes normally, whether or not it lands anywhere.

The control is a three-state machine. ST_IDLE accepts a request and moves to ST_EXEC. ST_EXEC performs the lookup, builds the completion, commits any scratch write and moves to ST_RESP. ST_RESP presents the completion until the requester takes it and then returns to ST_IDLE. Synchronous reset forces ST_IDLE.

Top module: `cfgdec_top`

## Requirements
- R1: Only bus 0 is claimed. A request with a nonzero bus number is treated as a missing function, whatever device, function and offset it carries.
- R2: The implemented device/function pairs and their 16-bit device IDs are: 0/0=D130h, 3/0=D138h, 4/0=D139h, 5/0=D13Ah, 6/0=D13Bh, 8/0=D155h, 8/1=D156h, 8/2=D157h, 8/3=D158h, 16/0=D150h and 16/1=D151h. A read at offset 00h returns {device ID, VENDOR_ID} with the device ID in bits 31:16, with status 0. VENDOR_ID defaults to 1B2Ch.
- R3: A read to a missing device or function returns 32'hFFFF_FFFF with status 1 (master abort).
- R4: A write to a missing device or function has no effect on any register and completes with status 0. Status 1 is never returned for a write.
- R5: Inside an implemented function, a read of any offset other than 00h, 08h and 40h returns zero with status 0. A write there is ignored and completes with status 0.
- R6: A read at offset 08h of an implemented function returns the class word CLASS_REV (default 32'h0600_0000) with status 0.
- R7: Each implemented function has its own scratch register at offset 40h. Write-enable bit i updates byte i (bits 8i+7:8i), and bytes whose enable is clear keep their value.
- R8: Bits set in SCR_RSVD_MASK (default bit 31) read as zero from the scratch register, whatever data was written to them.
- R9: A request is accepted only on a cycle with req_valid and req_ready both high. Each accepted request produces exactly one response, and no new request is accepted until that response is taken. rsp_valid, rsp_rdata and rsp_status hold steady while rsp_ready is low. A write response carries zero data.
- R10: A synchronous reset clears every scratch register to zero and drops rsp_valid. req_ready stays low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 8 | Register byte offset; bits 1:0 are ignored |
| req_be | input | 4 | Write byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Completion present |
| rsp_ready | input | 1 | Requester takes the completion |
| rsp_rdata | output | 32 | Read data |
| rsp_status | output | 1 | 0 = normal, 1 = master abort |

## Verification
The bench probes both defaults for unimplemented targets. A decoder that mixed them up would return zeros for a missing function, or all ones with an abort status for a missing register. It sends requests on a nonzero bus whose device and function match real entries, to catch a decoder that ignores the bus number. It then reads back scratch registers after writes that should have been dropped, after partial byte enables and after writes to the reserved bit, which exposes writes that land in the wrong function or the wrong bytes. It also holds off the response and resets in mid-run to confirm that completions stay stable and that scratch contents are cleared.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 8;
    localparam int DW     = 32;
    localparam int BE_W   = DW / 8;
    localparam int DID_W  = 16;
    localparam int NUM_FN = 11;
    localparam int IDX_W  = $clog2(NUM_FN);
    localparam int DWI_W  = OFF_W - 2;

    // dword indices of the implemented registers
    localparam logic [DWI_W-1:0] DWI_ID    = 6'h00;
    localparam logic [DWI_W-1:0] DWI_CLASS = 6'h02;
    localparam logic [DWI_W-1:0] DWI_SCR   = 6'h10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } state_e;
endpackage

// File: rtl/cfgdec_fn_lookup.sv
module cfgdec_fn_lookup
    import cfgdec_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [DID_W-1:0] did
);
    logic             tbl_hit;
    logic [IDX_W-1:0] tbl_idx;
    logic [DID_W-1:0] tbl_did;

    always_comb begin
        tbl_hit = 1'b1;
        tbl_idx = '0;
        tbl_did = '0;
        case ({dev, fn})
            {5'd0,  3'd0}: begin tbl_idx = 4'd0;  tbl_did = 16'hD130; end
            {5'd3,  3'd0}: begin tbl_idx = 4'd1;  tbl_did = 16'hD138; end
            {5'd4,  3'd0}: begin tbl_idx = 4'd2;  tbl_did = 16'hD139; end
            {5'd5,  3'd0}: begin tbl_idx = 4'd3;  tbl_did = 16'hD13A; end
            {5'd6,  3'd0}: begin tbl_idx = 4'd4;  tbl_did = 16'hD13B; end
            {5'd8,  3'd0}: begin tbl_idx = 4'd5;  tbl_did = 16'hD155; end
            {5'd8,  3'd1}: begin tbl_idx = 4'd6;  tbl_did = 16'hD156; end
            {5'd8,  3'd2}: begin tbl_idx = 4'd7;  tbl_did = 16'hD157; end
            {5'd8,  3'd3}: begin tbl_idx = 4'd8;  tbl_did = 16'hD158; end
            {5'd16, 3'd0}: begin tbl_idx = 4'd9;  tbl_did = 16'hD150; end
            {5'd16, 3'd1}: begin tbl_idx = 4'd10; tbl_did = 16'hD151; end
            default:       tbl_hit = 1'b0;
        endcase
    end

    // only bus zero is claimed
    assign hit = tbl_hit && (bus == '0);
    assign idx = tbl_idx;
    assign did = tbl_did;
endmodule

// File: rtl/cfgdec_scratch_bank.sv
module cfgdec_scratch_bank
    import cfgdec_pkg::*;
#(
    parameter logic [DW-1:0] RSVD_MASK = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [NUM_FN-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        logic [DW-1:0] scr_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                scr_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b])
                        scr_q[b*8 +: 8] <= wr_data[b*8 +: 8] & ~RSVD_MASK[b*8 +: 8];
                end
            end
        end
        assign bank[g] = scr_q;
    end

    assign rd_data = (rd_idx < IDX_W'(NUM_FN)) ? bank[rd_idx] : '0;
endmodule

// File: rtl/cfgdec_resp_build.sv
module cfgdec_resp_build
    import cfgdec_pkg::*;
#(
    parameter logic [DID_W-1:0] VENDOR_ID = 16'h1B2C,
    parameter logic [DW-1:0]    CLASS_REV = 32'h0600_0000
) (
    input  logic             is_write,
    input  logic             claimed,
    input  logic [DWI_W-1:0] dwi,
    input  logic [DID_W-1:0] did,
    input  logic [DW-1:0]    scr_val,
    output logic [DW-1:0]    data,
    output logic             status,
    output logic             scr_we
);
    always_comb begin
        data   = '0;
        status = 1'b0;
        scr_we = 1'b0;
        if (!claimed) begin
            if (!is_write) begin
                data   = '1;
                status = 1'b1;
            end
        end else if (is_write) begin
            scr_we = (dwi == DWI_SCR);
        end else begin
            case (dwi)
                DWI_ID:    data = {did, VENDOR_ID};
                DWI_CLASS: data = CLASS_REV;
                DWI_SCR:   data = scr_val;
                default:   data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter logic [DID_W-1:0] VENDOR_ID     = 16'h1B2C,
    parameter logic [DW-1:0]    CLASS_REV     = 32'h0600_0000,
    parameter logic [DW-1:0]    SCR_RSVD_MASK = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [FN_W-1:0]  req_fn,
    input  logic [OFF_W-1:0] req_off,
    input  logic [BE_W-1:0]  req_be,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_status
);
    state_e state_q, state_d;

    logic             rq_write;
    logic [BUS_W-1:0] rq_bus;
    logic [DEV_W-1:0] rq_dev;
    logic [FN_W-1:0]  rq_fn;
    logic [DWI_W-1:0] rq_dwi;
    logic [BE_W-1:0]  rq_be;
    logic [DW-1:0]    rq_wdata;

    logic             fn_hit;
    logic [IDX_W-1:0] fn_idx;
    logic [DID_W-1:0] fn_did;
    logic [DW-1:0]    scr_val;
    logic [DW-1:0]    bld_data;
    logic             bld_status;
    logic             bld_scr_we;

    logic             accept;
    logic             in_exec;
    logic [DW-1:0]    rdata_q;
    logic             status_q;

    cfgdec_fn_lookup u_lookup (
        .bus (rq_bus),
        .dev (rq_dev),
        .fn  (rq_fn),
        .hit (fn_hit),
        .idx (fn_idx),
        .did (fn_did)
    );

    cfgdec_scratch_bank #(
        .RSVD_MASK (SCR_RSVD_MASK)
    ) u_scratch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_exec && bld_scr_we),
        .wr_idx  (fn_idx),
        .wr_be   (rq_be),
        .wr_data (rq_wdata),
        .rd_idx  (fn_idx),
        .rd_data (scr_val)
    );

    cfgdec_resp_build #(
        .VENDOR_ID (VENDOR_ID),
        .CLASS_REV (CLASS_REV)
    ) u_build (
        .is_write (rq_write),
        .claimed  (fn_hit),
        .dwi      (rq_dwi),
        .did      (fn_did),
        .scr_val  (scr_val),
        .data     (bld_data),
        .status   (bld_status),
        .scr_we   (bld_scr_we)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        in_exec   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = !rst;
                if (req_valid && !rst) state_d = ST_EXEC;
            end
            ST_EXEC: begin
                in_exec = 1'b1;
                state_d = ST_RESP;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = req_valid && req_ready;

    // request capture and completion registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rq_write <= 1'b0;
            rq_bus   <= '0;
            rq_dev   <= '0;
            rq_fn    <= '0;
            rq_dwi   <= '0;
            rq_be    <= '0;
            rq_wdata <= '0;
            rdata_q  <= '0;
            status_q <= 1'b0;
        end else begin
            if (accept) begin
                rq_write <= req_write;
                rq_bus   <= req_bus;
                rq_dev   <= req_dev;
                rq_fn    <= req_fn;
                rq_dwi   <= req_off[OFF_W-1:2];
                rq_be    <= req_be;
                rq_wdata <= req_wdata;
            end
            if (in_exec) begin
                rdata_q  <= bld_data;
                status_q <= bld_status;
            end
        end
    end

    assign rsp_rdata  = rdata_q;
    assign rsp_status = status_q;
endmodule

// File: rtl/cfgdec_top_chk.sv
module cfgdec_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_rdata,
    input logic        rsp_status
);
    logic pend_q;
    logic pend_wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            pend_wr_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                pend_q    <= 1'b1;
                pend_wr_q <= req_write;
            end else if (rsp_valid && rsp_ready) begin
                pend_q <= 1'b0;
            end
        end
    end

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> !pend_q);

    assert_rsp_has_req_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> pend_q);

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_status)));

    assert_abort_ones_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status) |-> (rsp_rdata == 32'hFFFF_FFFF && !pend_wr_q));

    assert_write_normal_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && pend_wr_q) |-> (!rsp_status && rsp_rdata == 32'h0));

    assert_reset_no_ready_R10: assert property (@(posedge clk)
        rst |-> !req_ready);

    assert_reset_no_rsp_R10: assert property (@(posedge clk)
        rst |=> !rsp_valid);
endmodule

bind cfgdec_top cfgdec_top_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_status (rsp_status)
);

// File: tb/cfgdec_top_tb_top.sv
module cfgdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [7:0]  req_off = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_status;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfgdec_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_bus    (req_bus),
        .req_dev    (req_dev),
        .req_fn     (req_fn),
        .req_off    (req_off),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata),
        .rsp_status (rsp_status)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [7:0]  off;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic        exp_st;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h00, 4'h0, 32'h0, 32'hD1301B2C, 1'b0, 8'd2},  // R2
        '{1'b0, 8'd0, 5'd3,  3'd0, 8'h00, 4'h0, 32'h0, 32'hD1381B2C, 1'b0, 8'd2},  // R2
        '{1'b0, 8'd0, 5'd6,  3'd0, 8'h00, 4'h0, 32'h0, 32'hD13B1B2C, 1'b0, 8'd2},  // R2
        '{1'b0, 8'd0, 5'd8,  3'd3, 8'h00, 4'h0, 32'h0, 32'hD1581B2C, 1'b0, 8'd2},  // R2
        '{1'b0, 8'd0, 5'd16, 3'd1, 8'h00, 4'h0, 32'h0, 32'hD1511B2C, 1'b0, 8'd2},  // R2
        '{1'b0, 8'd0, 5'd1,  3'd0, 8'h00, 4'h0, 32'h0, 32'hFFFFFFFF, 1'b1, 8'd3},  // R3
        '{1'b0, 8'd0, 5'd8,  3'd4, 8'h40, 4'h0, 32'h0, 32'hFFFFFFFF, 1'b1, 8'd3},  // R3
        '{1'b0, 8'd1, 5'd0,  3'd0, 8'h00, 4'h0, 32'h0, 32'hFFFFFFFF, 1'b1, 8'd1},  // R1
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h08, 4'h0, 32'h0, 32'h06000000, 1'b0, 8'd6},  // R6
        '{1'b0, 8'd0, 5'd5,  3'd0, 8'h44, 4'h0, 32'h0, 32'h00000000, 1'b0, 8'd5},  // R5
        '{1'b1, 8'd0, 5'd0,  3'd0, 8'h40, 4'hF, 32'h12345678, 32'h0, 1'b0, 8'd7},  // R7
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h40, 4'h0, 32'h0, 32'h12345678, 1'b0, 8'd7},  // R7
        '{1'b0, 8'd0, 5'd3,  3'd0, 8'h40, 4'h0, 32'h0, 32'h00000000, 1'b0, 8'd7},  // R7 separate
        '{1'b1, 8'd0, 5'd3,  3'd0, 8'h40, 4'h5, 32'hAABBCCDD, 32'h0, 1'b0, 8'd7},  // R7 partial
        '{1'b0, 8'd0, 5'd3,  3'd0, 8'h40, 4'h0, 32'h0, 32'h00BB00DD, 1'b0, 8'd7},  // R7
        '{1'b1, 8'd0, 5'd16, 3'd1, 8'h40, 4'hF, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd8},  // R8
        '{1'b0, 8'd0, 5'd16, 3'd1, 8'h40, 4'h0, 32'h0, 32'h7FFFFFFF, 1'b0, 8'd8},  // R8
        '{1'b1, 8'd2, 5'd0,  3'd0, 8'h40, 4'hF, 32'h0, 32'h0, 1'b0, 8'd4},         // R4 bus 2
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h40, 4'h0, 32'h0, 32'h12345678, 1'b0, 8'd4},  // R4 unchanged
        '{1'b1, 8'd0, 5'd7,  3'd0, 8'h40, 4'hF, 32'h1, 32'h0, 1'b0, 8'd4},         // R4 missing dev
        '{1'b1, 8'd0, 5'd0,  3'd0, 8'h44, 4'hF, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd5},  // R5 write
        '{1'b0, 8'd0, 5'd0,  3'd0, 8'h44, 4'h0, 32'h0, 32'h00000000, 1'b0, 8'd5},  // R5 read back
        '{1'b0, 8'd0, 5'd8,  3'd0, 8'h04, 4'h0, 32'h0, 32'h00000000, 1'b0, 8'd5}   // R5
    };

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input vec_t v, output logic [31:0] data, output logic st);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = v.wr;
        req_bus   = v.bus;
        req_dev   = v.dev;
        req_fn    = v.fn;
        req_off   = v.off;
        req_be    = v.be;
        req_wdata = v.wdata;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        while (!rsp_valid) @(negedge clk);
        data = rsp_rdata;
        st   = rsp_status;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        logic        s;
        vec_t        v;

        // reset state
        repeat (3) @(negedge clk);
        check(10, "ready in reset", {31'b0, req_ready}, 32'd0);
        check(10, "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(9, "ready after reset", {31'b0, req_ready}, 32'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i], d, s);
            check(int'(VEC[i].rq), $sformatf("vec %0d data", i), d, VEC[i].exp_data);
            check(int'(VEC[i].rq), $sformatf("vec %0d status", i), {31'b0, s}, {31'b0, VEC[i].exp_st});
        end

        // R9: response held under backpressure, no second accept
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0;
        req_dev = 5'd4; req_fn = 3'd0; req_off = 8'h00; req_be = 4'h0;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check(9, "held rsp_valid", {31'b0, rsp_valid}, 32'd1);
            check(9, "held data", rsp_rdata, 32'hD1391B2C);
            check(9, "no accept while busy", {31'b0, req_ready}, 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(9, "rsp dropped after take", {31'b0, rsp_valid}, 32'd0);

        // R10: reset in mid-run clears scratch
        v = '{1'b1, 8'd0, 5'd4, 3'd0, 8'h40, 4'hF, 32'h00000055, 32'h0, 1'b0, 8'd10};
        do_req(v, d, s);
        v = '{1'b0, 8'd0, 5'd4, 3'd0, 8'h40, 4'h0, 32'h0, 32'h0, 1'b0, 8'd10};
        do_req(v, d, s);
        check(10, "scratch before reset", d, 32'h00000055);
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(10, "ready during reset", {31'b0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        rst = 1'b0;
        do_req(v, d, s);
        check(10, "scratch cleared by reset", d, 32'h0);
        v = '{1'b0, 8'd0, 5'd0, 3'd0, 8'h40, 4'h0, 32'h0, 32'h0, 1'b0, 8'd10};
        do_req(v, d, s);
        check(10, "scratch fn0 cleared", d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule